// File: doc/BRIEF.md
# Multi-Register Block Transfer Sequencer

This block is the sequencing engine for an instruction that moves a group of registers to or from consecutive memory words. A single start pulse hands it a 16-bit selection mask, a base address, the index of the base register and four mode bits: step before or after each access, walk upward or downward, write the final address back, and load or store. A fifth input requests a privileged register-bank switch. The sequencer does not support that switch, so any such request is rejected.

Once started, the sequencer visits the selected registers one by one. It makes one word access per accepted memory cycle on a request/ready interface. Register values come from, and loaded words go to, an indexed register-file port outside the block. When the walk ends, the block raises done for one cycle together with the final address. If write-back is selected, it also writes that address into the base register through the same register-file write port. Neither the memory nor the register file is part of the block.

Top module: `blk_xfer_seq`

## Requirements
- R1: Mask bit i selects register i. Each selected register is transferred exactly once, and no unselected register is transferred.
- R2: If mask bit 15 is set or `bank_sel` is 1 when the operation starts, the block raises `done` with `illegal`=1 in the next cycle. It makes no memory request and performs no register write.
- R3: With `step_up`=1 the registers are visited in ascending index order. With `step_up`=0 they are visited in descending order.
- R4: For the k-th transfer (k counted from 0) the address is base+4(k+1) when `pre_step`=1 and `step_up`=1, and base+4k when `pre_step`=0 and `step_up`=1. The downward cases use base-4(k+1) and base-4k.
- R5: With `load`=1, `mem_we` is 0. In the accepted cycle the block writes `mem_rdata` to the register at `rf_ridx`. With `load`=0, `mem_we` is 1 and `mem_wdata` equals the register-file value at `rf_ridx`.
- R6: In the done cycle of a legal operation, `final_addr` equals base±4n, where n is the number of selected registers. When `writeback`=1, `rf_we` is 1 with `rf_widx`=`base_idx` and `rf_wdata`=`final_addr`. When `writeback`=0, `rf_we` is 0.
- R7: An empty mask leads to `done` in the cycle after the start, with no memory request. Write-back still applies.
- R8: While `mem_req` is 1 and `mem_rdy` is 0, the request, its address and `rf_ridx` stay unchanged in the next cycle.
- R9: `done` is a single-cycle pulse that follows the last accepted transfer. After reset, `done`, `mem_req` and `rf_we` are 0.
- R10: The two low bits of `mem_addr` are 0 on every request, even when the base address is not word aligned.
- R11: A start pulse while an operation is in progress has no effect on the operation under way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation (taken only when idle) |
| reg_list | input | 16 | Register selection mask |
| base_addr | input | 32 | Starting address |
| base_idx | input | 4 | Index of the base register for write-back |
| pre_step | input | 1 | 1: step address before each access, 0: after |
| step_up | input | 1 | 1: ascending walk, 0: descending |
| writeback | input | 1 | Write final address into base register |
| load | input | 1 | 1: memory to registers, 0: registers to memory |
| bank_sel | input | 1 | Bank-switch request; always rejected |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 32 | Word-aligned access address |
| mem_wdata | output | 32 | Store data |
| mem_rdata | input | 32 | Load data, valid with mem_rdy |
| mem_rdy | input | 1 | Access accepted this cycle |
| rf_ridx | output | 4 | Register-file read/transfer index |
| rf_rdata | input | 32 | Register-file read data |
| rf_we | output | 1 | Register-file write enable |
| rf_widx | output | 4 | Register-file write index |
| rf_wdata | output | 32 | Register-file write data |
| done | output | 1 | Operation finished (one cycle) |
| final_addr | output | 32 | Address after the last step, valid with done |
| illegal | output | 1 | Operation rejected, valid with done |

## Verification
The bench crosses all eight combinations of step timing, direction and transfer kind with empty, single-bit, full and pseudo-random masks. Single-bit masks separate the pre- and post-step address offsets. Multi-bit masks expose ordering errors between the ascending and descending walks. Memory readiness follows a pseudo-random pattern, so stalls land on first, middle and last transfers, which tests hold behaviour apart from address stepping. Misaligned bases, trap-bit and bank-switch masks, and a start pulse injected mid-operation cover the alignment, rejection and busy cases.

// File: rtl/blk_xfer_pkg.sv
package blk_xfer_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } xfer_state_e;

  typedef struct packed {
    logic pre;
    logic up;
    logic wb;
    logic ld;
  } xfer_mode_t;

endpackage

// File: rtl/blk_xfer_pick.sv
// Picks the next register to transfer from the remaining mask:
// lowest set bit for an upward walk, highest for a downward walk.
module blk_xfer_pick #(
  parameter int N  = 16,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  mask,
  input  logic          up,
  output logic [IW-1:0] idx
);

  logic [IW-1:0] lo_idx;
  logic [IW-1:0] hi_idx;

  always_comb begin
    lo_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (mask[i]) lo_idx = IW'(i);
    end
  end

  always_comb begin
    hi_idx = '0;
    for (int i = 0; i < N; i++) begin
      if (mask[i]) hi_idx = IW'(i);
    end
  end

  assign idx = up ? lo_idx : hi_idx;

endmodule

// File: rtl/blk_xfer_addr.sv
// Address stepping: the effective address of the current access and the
// running address after it. Both pre and post modes advance by one word.
module blk_xfer_addr #(
  parameter int AW    = 32,
  parameter int STEP  = 4
) (
  input  logic [AW-1:0] cur_addr,
  input  logic          up,
  input  logic          pre,
  output logic [AW-1:0] eff_addr,
  output logic [AW-1:0] next_addr
);

  localparam logic [AW-1:0] STEP_V = AW'(STEP);
  localparam logic [AW-1:0] ALIGN_MASK = ~(AW'(STEP - 1));

  logic [AW-1:0] stepped;

  assign stepped   = up ? (cur_addr + STEP_V) : (cur_addr - STEP_V);
  assign next_addr = stepped;
  assign eff_addr  = (pre ? stepped : cur_addr) & ALIGN_MASK;

endmodule

// File: rtl/blk_xfer_seq.sv
module blk_xfer_seq
  import blk_xfer_pkg::*;
#(
  parameter int REG_CNT    = 16,
  parameter int IDX_W      = $clog2(REG_CNT),
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int WORD_BYTES = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic [REG_CNT-1:0] reg_list,
  input  logic [ADDR_W-1:0]  base_addr,
  input  logic [IDX_W-1:0]   base_idx,
  input  logic               pre_step,
  input  logic               step_up,
  input  logic               writeback,
  input  logic               load,
  input  logic               bank_sel,
  output logic               mem_req,
  output logic               mem_we,
  output logic [ADDR_W-1:0]  mem_addr,
  output logic [DATA_W-1:0]  mem_wdata,
  input  logic [DATA_W-1:0]  mem_rdata,
  input  logic               mem_rdy,
  output logic [IDX_W-1:0]   rf_ridx,
  input  logic [DATA_W-1:0]  rf_rdata,
  output logic               rf_we,
  output logic [IDX_W-1:0]   rf_widx,
  output logic [DATA_W-1:0]  rf_wdata,
  output logic               done,
  output logic [ADDR_W-1:0]  final_addr,
  output logic               illegal
);

  localparam int TRAP_BIT = REG_CNT - 1;

  xfer_state_e        state_q;
  xfer_mode_t         mode_q;
  logic [REG_CNT-1:0] rem_q;
  logic [ADDR_W-1:0]  addr_q;
  logic [IDX_W-1:0]   base_idx_q;
  logic               illegal_q;

  logic [IDX_W-1:0]   cur_idx;
  logic [REG_CNT-1:0] cur_onehot;
  logic [REG_CNT-1:0] rem_next;
  logic [ADDR_W-1:0]  eff_addr;
  logic [ADDR_W-1:0]  next_addr;
  logic               xfer;
  logic               reject;

  blk_xfer_pick #(
    .N  (REG_CNT),
    .IW (IDX_W)
  ) u_pick (
    .mask (rem_q),
    .up   (mode_q.up),
    .idx  (cur_idx)
  );

  blk_xfer_addr #(
    .AW   (ADDR_W),
    .STEP (WORD_BYTES)
  ) u_addr (
    .cur_addr  (addr_q),
    .up        (mode_q.up),
    .pre       (mode_q.pre),
    .eff_addr  (eff_addr),
    .next_addr (next_addr)
  );

  for (genvar g = 0; g < REG_CNT; g++) begin : g_clr
    assign cur_onehot[g] = (cur_idx == IDX_W'(g));
  end

  assign rem_next = rem_q & ~cur_onehot;
  assign reject   = reg_list[TRAP_BIT] | bank_sel;
  assign xfer     = (state_q == ST_RUN) & mem_rdy;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      mode_q     <= '0;
      rem_q      <= '0;
      addr_q     <= '0;
      base_idx_q <= '0;
      illegal_q  <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (start) begin
            mode_q     <= '{pre: pre_step, up: step_up, wb: writeback, ld: load};
            addr_q     <= base_addr;
            base_idx_q <= base_idx;
            illegal_q  <= reject;
            if (reject) begin
              rem_q   <= '0;
              state_q <= ST_DONE;
            end else begin
              rem_q   <= reg_list;
              state_q <= (|reg_list) ? ST_RUN : ST_DONE;
            end
          end
        end
        ST_RUN: begin
          if (mem_rdy) begin
            rem_q  <= rem_next;
            addr_q <= next_addr;
            if (rem_next == '0) state_q <= ST_DONE;
          end
        end
        default: begin
          state_q <= ST_IDLE;
        end
      endcase
    end
  end

  assign mem_req    = (state_q == ST_RUN);
  assign mem_we     = mem_req & ~mode_q.ld;
  assign mem_addr   = eff_addr;
  assign mem_wdata  = rf_rdata;
  assign rf_ridx    = cur_idx;

  assign done       = (state_q == ST_DONE);
  assign final_addr = addr_q;
  assign illegal    = done & illegal_q;

  assign rf_we      = (xfer & mode_q.ld) | (done & mode_q.wb & ~illegal_q);
  assign rf_widx    = done ? base_idx_q : cur_idx;
  assign rf_wdata   = done ? DATA_W'(addr_q) : mem_rdata;

endmodule

// File: rtl/blk_xfer_seq_chk.sv
module blk_xfer_seq_chk #(
  parameter int REG_CNT    = 16,
  parameter int IDX_W      = 4,
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int WORD_BYTES = 4
) (
  input logic               clk,
  input logic               rst,
  input logic               idle,
  input logic               start,
  input logic [REG_CNT-1:0] reg_list,
  input logic               bank_sel,
  input logic               mem_req,
  input logic               mem_rdy,
  input logic [ADDR_W-1:0]  mem_addr,
  input logic [IDX_W-1:0]   rf_ridx,
  input logic               rf_we,
  input logic [IDX_W-1:0]   rf_widx,
  input logic [DATA_W-1:0]  rf_wdata,
  input logic               done,
  input logic               illegal,
  input logic [ADDR_W-1:0]  final_addr,
  input logic               dir_up,
  input logic               wb_q,
  input logic [IDX_W-1:0]   base_idx_q
);

  localparam int ALIGN_W = $clog2(WORD_BYTES);
  localparam logic [ADDR_W-1:0] STEP_V = ADDR_W'(WORD_BYTES);

  AST_TRAP_NO_ACCESS: assert property (@(posedge clk) disable iff (rst)
    (idle && start && (reg_list[REG_CNT-1] || bank_sel)) |=> (done && illegal && !mem_req && !rf_we)); // R2

  AST_EMPTY_LIST: assert property (@(posedge clk) disable iff (rst)
    (idle && start && !bank_sel && reg_list == '0) |=> (done && !illegal && !mem_req)); // R7

  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_rdy) |=> (mem_req && $stable(mem_addr) && $stable(rf_ridx))); // R8

  AST_WORD_ALIGN: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> (mem_addr[ALIGN_W-1:0] == '0)); // R10

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> (!done && !mem_req)); // R9

  AST_ASCEND: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_rdy && dir_up) |=> (!mem_req || rf_ridx > $past(rf_ridx))); // R3

  AST_DESCEND: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_rdy && !dir_up) |=> (!mem_req || rf_ridx < $past(rf_ridx))); // R3

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_rdy) |=> (!mem_req ||
      mem_addr == (dir_up ? $past(mem_addr) + STEP_V : $past(mem_addr) - STEP_V))); // R4

  AST_WRITEBACK: assert property (@(posedge clk) disable iff (rst)
    (done && !illegal && wb_q) |-> (rf_we && rf_widx == base_idx_q &&
      rf_wdata == DATA_W'(final_addr))); // R6

endmodule

bind blk_xfer_seq blk_xfer_seq_chk #(
  .REG_CNT    (REG_CNT),
  .IDX_W      (IDX_W),
  .ADDR_W     (ADDR_W),
  .DATA_W     (DATA_W),
  .WORD_BYTES (WORD_BYTES)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .idle       (state_q == blk_xfer_pkg::ST_IDLE),
  .start      (start),
  .reg_list   (reg_list),
  .bank_sel   (bank_sel),
  .mem_req    (mem_req),
  .mem_rdy    (mem_rdy),
  .mem_addr   (mem_addr),
  .rf_ridx    (rf_ridx),
  .rf_we      (rf_we),
  .rf_widx    (rf_widx),
  .rf_wdata   (rf_wdata),
  .done       (done),
  .illegal    (illegal),
  .final_addr (final_addr),
  .dir_up     (mode_q.up),
  .wb_q       (mode_q.wb),
  .base_idx_q (base_idx_q)
);

// File: tb/blk_xfer_seq_bench.sv
module blk_xfer_seq_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [15:0] reg_list = '0;
  logic [31:0] base_addr = '0;
  logic [3:0]  base_idx = 4'd13;
  logic        pre_step = 1'b0;
  logic        step_up = 1'b0;
  logic        writeback = 1'b0;
  logic        load = 1'b0;
  logic        bank_sel = 1'b0;
  logic        mem_req;
  logic        mem_we;
  logic [31:0] mem_addr;
  logic [31:0] mem_wdata;
  logic [31:0] mem_rdata;
  logic        mem_rdy = 1'b0;
  logic [3:0]  rf_ridx;
  logic [31:0] rf_rdata;
  logic        rf_we;
  logic [3:0]  rf_widx;
  logic [31:0] rf_wdata;
  logic        done;
  logic [31:0] final_addr;
  logic        illegal;

  int n_chk = 0;
  int n_bad = 0;
  logic [15:0] lf = 16'hACE1;

  logic [31:0] rf  [16];
  logic [31:0] mem [256];

  always #10 clk = ~clk;

  blk_xfer_seq u_blk_xfer_seq (
    .clk(clk), .rst(rst), .start(start), .reg_list(reg_list),
    .base_addr(base_addr), .base_idx(base_idx), .pre_step(pre_step),
    .step_up(step_up), .writeback(writeback), .load(load), .bank_sel(bank_sel),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_rdy(mem_rdy),
    .rf_ridx(rf_ridx), .rf_rdata(rf_rdata), .rf_we(rf_we), .rf_widx(rf_widx),
    .rf_wdata(rf_wdata), .done(done), .final_addr(final_addr), .illegal(illegal)
  );

  assign rf_rdata  = rf[rf_ridx];
  assign mem_rdata = mem[mem_addr[9:2]];

  always @(posedge clk) begin
    if (rf_we) rf[rf_widx] <= rf_wdata;
    if (mem_req && mem_rdy && mem_we) mem[mem_addr[9:2]] <= mem_wdata;
  end

  function automatic logic [31:0] rpat(input int i);
    return 32'h1000_0000 + i * 32'h111;
  endfunction

  function automatic logic [31:0] mpat(input logic [31:0] a);
    return 32'hC000_0000 | a;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step_lf();
    lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
  endtask

  task automatic run_op(input logic [15:0] lst, input logic p, input logic u,
                        input logic w, input logic l, input logic s,
                        input logic [31:0] base, input bit poke);
    int exi [16];
    int n;
    int k;
    int guard;
    bit stl;
    bit poked;
    logic exp_ill;
    logic [31:0] fin;
    logic [31:0] ea;
    logic [31:0] s_addr;
    logic [3:0]  s_idx;

    n = 0;
    for (int i = 0; i < 16; i++) begin
      int j;
      j = u ? i : 15 - i;
      if (lst[j]) begin
        exi[n] = j;
        n++;
      end
    end
    exp_ill = lst[15] | s;
    fin = u ? base + 32'(4 * n) : base - 32'(4 * n);

    @(negedge clk);
    for (int i = 0; i < 16; i++) rf[i] = rpat(i);
    for (int i = 0; i < 256; i++) mem[i] = mpat(32'(i * 4));
    reg_list = lst; pre_step = p; step_up = u; writeback = w; load = l;
    bank_sel = s; base_addr = base; start = 1'b1; mem_rdy = 1'b0;
    @(negedge clk);
    start = 1'b0;

    k = 0; guard = 0; stl = 0; poked = 0;
    forever begin
      mem_rdy = lf[0] | lf[2];
      step_lf();
      #1;
      if (done) break;
      if (exp_ill || n == 0) begin
        chk(0, "R2/R7 done not in cycle after start", 32'(done), 32'd1);
        break;
      end
      guard++;
      if (guard > 2000) begin
        chk(0, "WATCHDOG R1", 32'(k), 32'(n));
        break;
      end
      chk(mem_req == 1'b1, "R1 request active", 32'(mem_req), 32'd1);
      if (stl) chk(mem_addr == s_addr && rf_ridx == s_idx, "R8 hold", mem_addr, s_addr);
      if (mem_rdy && mem_req) begin
        if (k >= n) begin
          chk(0, "R1 extra transfer", 32'(k), 32'(n));
        end else begin
          if (u) ea = p ? base + 32'(4 * (k + 1)) : base + 32'(4 * k);
          else   ea = p ? base - 32'(4 * (k + 1)) : base - 32'(4 * k);
          ea = ea & ~32'd3;
          chk(32'(rf_ridx) == 32'(exi[k]), "R3 order", 32'(rf_ridx), 32'(exi[k]));
          chk(mem_addr == ea, "R4 address", mem_addr, ea);
          chk(mem_addr[1:0] == 2'b00, "R10 align", mem_addr, ea);
          chk(mem_we == !l, "R5 direction", 32'(mem_we), 32'(!l));
          if (l) chk(rf_we && 32'(rf_widx) == 32'(exi[k]) && rf_wdata == mpat(ea),
                     "R5 load data", rf_wdata, mpat(ea));
          else   chk(mem_wdata == rpat(exi[k]), "R5 store data", mem_wdata, rpat(exi[k]));
        end
        k++;
        stl = 0;
      end else begin
        stl = 1;
        s_addr = mem_addr;
        s_idx = rf_ridx;
      end
      if (poke && k == 1 && !poked) begin
        start = 1'b1; bank_sel = 1'b1; reg_list = 16'h8000; poked = 1;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
    end
    start = 1'b0;

    if (done) begin
      chk(illegal == exp_ill, poke ? "R11 busy start ignored" : "R2 illegal flag",
          32'(illegal), 32'(exp_ill));
      chk(!mem_req, "R9 no request at done", 32'(mem_req), 32'd0);
      if (exp_ill) begin
        chk(k == 0 && !rf_we, "R2 no access", 32'(k), 32'd0);
      end else begin
        chk(k == n, "R1 transfer count", 32'(k), 32'(n));
        chk(final_addr == fin, "R6 final address", final_addr, fin);
        chk(rf_we == w, "R6 write-back enable", 32'(rf_we), 32'(w));
        if (w) chk(rf_widx == 4'd13 && rf_wdata == fin, "R6 write-back data", rf_wdata, fin);
        if (n == 0) chk(rf_we == w, "R7 empty list write-back", 32'(rf_we), 32'(w));
      end
    end
    mem_rdy = 1'b0;
    @(negedge clk);
    #1;
    chk(!done, "R9 done single cycle", 32'(done), 32'd0);
  endtask

  initial begin : watchdog
    #3_000_000;
    n_bad++;
    $display("FAIL WATCHDOG R9 run did not finish actual=%h expected=%h", 32'd0, 32'd1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    logic [15:0] rm;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    chk(!done && !mem_req && !rf_we, "R9 reset state", {29'd0, done, mem_req, rf_we}, 32'd0);

    for (int m = 0; m < 16; m++) begin
      logic p;
      logic u;
      logic l;
      logic w;
      p = m[0]; u = m[1]; l = m[2]; w = m[3];
      run_op(16'h0000, p, u, w, l, 1'b0, 32'h200, 0);
      run_op(16'h7FFF, p, u, w, l, 1'b0, 32'h200, 0);
      for (int b = 0; b < 15; b++) run_op(16'(1 << b), p, u, w, l, 1'b0, 32'h200, 0);
      for (int r = 0; r < 10; r++) begin
        step_lf();
        rm = lf & 16'h7FFF;
        run_op(rm, p, u, w, l, 1'b0, (r % 3 == 0) ? 32'h203 : 32'h201 + 32'(r), 0);
      end
      run_op(16'h8000, p, u, w, l, 1'b0, 32'h200, 0);
      run_op(16'h8421, p, u, w, l, 1'b0, 32'h200, 0);
      run_op(16'h0003, p, u, w, l, 1'b1, 32'h200, 0);
    end

    run_op(16'h0F0F, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 32'h200, 1);
    run_op(16'h3C3C, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 32'h200, 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule